// File: doc/BRIEF.md
# GCI Serial Timeslot Interface

This block links a parallel channel store to a four-wire-plus-strobes serial timeslot bus of the kind used between a line transceiver and attached codecs or controllers. From a single master clock it generates a bit clock, a data clock running at twice the bit rate, and a frame sync. It transmits one byte per timeslot on the downstream data line and assembles the bytes arriving on the upstream data line. With the default settings a frame holds 12 timeslots of 8 bits, which is 96 bit periods. One bit period lasts 10 master-clock cycles, so a 7.68 MHz master clock gives a 768 kHz bit clock, a 1.536 MHz data clock and an 8 kHz frame.

The block has two independent strobe outputs. Each one can be placed on any timeslot so that a device on the bus knows when its byte is present. The same write port loads the downstream bytes and the strobe settings. A separate combinational read port returns the last upstream byte captured in each timeslot.

Top module: `gci_tsi`

## Requirements
- R1: The bit clock output is high for the first 5 and low for the last 5 master cycles of every 10-cycle bit period.
- R2: The data clock output has a period of 5 master cycles. It is high for 3 cycles and low for 2, and it rises at master cycle 0 and at master cycle 5 of each bit period.
- R3: The frame sync output is high for master cycles 0 to 4 of bit 0 in each 96-bit frame and low at all other times.
- R4: Timeslot s occupies bits 8s to 8s+7 of the frame. The downstream line carries the byte stored at write address s (0 to 11), most significant bit first. The line changes only at master cycle 0 of a bit, and a write becomes visible from the next bit start.
- R5: The upstream line is sampled at the second data-clock rise of each bit, which is master cycle 5. After the eighth bit of timeslot s, the assembled byte (first bit as the MSB) is read from read address s and is kept until the same slot in the next frame.
- R6: Strobe k (k = 0, 1) is configured by a write to address 12+k. Bit 7 is the enable and bits 3:0 are the slot. When enabled, the strobe is high for exactly the 8 bit periods of that slot, and the two strobes operate independently. A configuration write takes effect at the next bit start.
- R7: A strobe whose enable bit is 0 stays low.
- R8: A strobe slot value of 12 to 15 never asserts the strobe. Writes to addresses 14 and 15 change no output.
- R9: While reset is applied, every output is low and all stored bytes and strobe settings are cleared. Counting restarts at bit 0 of a frame on the third rising clock edge after reset is released.
- R10: A read address of 12 or higher returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 4 | Write address: 0-11 slot bytes, 12-13 strobe settings |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address for captured upstream bytes |
| rd_data | output | 8 | Captured upstream byte, or 0 when out of range |
| ser_up_i | input | 1 | Upstream serial data |
| ser_dn_o | output | 1 | Downstream serial data |
| bit_clk_o | output | 1 | Bit clock |
| dat_clk_o | output | 1 | Data clock, twice the bit rate |
| frame_sync_o | output | 1 | Frame sync |
| slot_strobe_o | output | 2 | Programmable timeslot strobes |

## Verification
Three downstream sets are used: all-zero bytes, bytes with mixed bit patterns, and bytes rewritten in the middle of a frame. Together they expose a wrong bit order, a wrong slot mapping, and output changes away from the bit boundary. The upstream line toggles pseudo-randomly on every master cycle, so a sample taken one cycle early or late produces a different captured byte. The strobe settings run through enabled, disabled, out-of-range, slot 0 (which coincides with the frame sync) and slot 11 (which wraps at the frame end). A reset in the middle of the run checks that the outputs clear and that framing restarts.

// File: rtl/gci_tsi_pkg.sv
package gci_tsi_pkg;
  localparam int unsigned SLOT_FIELD_W = 4;
  localparam int unsigned REG_ADDR_W   = 4;

  typedef struct packed {
    logic                    en;
    logic [SLOT_FIELD_W-1:0] slot;
  } strb_cfg_t;
endpackage

// File: rtl/gci_tsi_clkgen.sv
module gci_tsi_clkgen
  import gci_tsi_pkg::*;
#(
  parameter int unsigned MC_PER_BIT = 10,
  parameter int unsigned NBITS      = 96,
  parameter int unsigned SLOT_BITS  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic                         bit_adv_o,
  output logic                         samp_o,
  output logic [SLOT_FIELD_W-1:0]      slot_nxt_o,
  output logic [$clog2(SLOT_BITS)-1:0] pos_nxt_o,
  output logic [SLOT_FIELD_W-1:0]      slot_cur_o,
  output logic [$clog2(SLOT_BITS)-1:0] pos_cur_o,
  output logic                         bit_clk_o,
  output logic                         dat_clk_o,
  output logic                         frame_sync_o
);
  localparam int unsigned HALF  = MC_PER_BIT / 2;
  localparam int unsigned DHI   = (HALF + 1) / 2;
  localparam int unsigned MC_W  = $clog2(MC_PER_BIT);
  localparam int unsigned BIT_W = $clog2(NBITS);
  localparam int unsigned POS_W = $clog2(SLOT_BITS);

  logic [MC_W-1:0]  mc_q, mc_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             bclk_d, dclk_d, fs_d;
  logic             bclk_q, dclk_q, fs_q;

  // next-state
  always_comb begin
    mc_d  = mc_q + 1'b1;
    bit_d = bit_q;
    if (mc_q == MC_W'(MC_PER_BIT - 1)) begin
      mc_d  = '0;
      bit_d = (bit_q == BIT_W'(NBITS - 1)) ? '0 : bit_q + 1'b1;
    end
    bclk_d = (mc_d < MC_W'(HALF));
    dclk_d = (mc_d < MC_W'(DHI)) ||
             ((mc_d >= MC_W'(HALF)) && (mc_d < MC_W'(HALF + DHI)));
    fs_d   = (bit_d == '0) && (mc_d < MC_W'(HALF));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q   <= MC_W'(MC_PER_BIT - 1);
      bit_q  <= BIT_W'(NBITS - 1);
      bclk_q <= 1'b0;
      dclk_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      mc_q   <= mc_d;
      bit_q  <= bit_d;
      bclk_q <= bclk_d;
      dclk_q <= dclk_d;
      fs_q   <= fs_d;
    end
  end

  assign bit_adv_o    = (mc_d == '0);
  assign samp_o       = (mc_d == MC_W'(HALF));
  assign slot_nxt_o   = SLOT_FIELD_W'(bit_d / SLOT_BITS);
  assign pos_nxt_o    = POS_W'(bit_d % SLOT_BITS);
  assign slot_cur_o   = SLOT_FIELD_W'(bit_q / SLOT_BITS);
  assign pos_cur_o    = POS_W'(bit_q % SLOT_BITS);
  assign bit_clk_o    = bclk_q;
  assign dat_clk_o    = dclk_q;
  assign frame_sync_o = fs_q;
endmodule

// File: rtl/gci_tsi_tx.sv
module gci_tsi_tx
  import gci_tsi_pkg::*;
#(
  parameter int unsigned NSLOT     = 12,
  parameter int unsigned SLOT_BITS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [REG_ADDR_W-1:0]        wr_addr,
  input  logic [SLOT_BITS-1:0]         wr_data,
  input  logic                         bit_adv,
  input  logic [SLOT_FIELD_W-1:0]      slot_nxt,
  input  logic [$clog2(SLOT_BITS)-1:0] pos_nxt,
  output logic                         ser_dn_o
);
  localparam int unsigned POS_W = $clog2(SLOT_BITS);

  logic [NSLOT-1:0][SLOT_BITS-1:0] dn_mem;
  logic [POS_W-1:0]                bsel;
  logic                            dn_d, dn_q;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic we;
    assign we = wr_en && (wr_addr == REG_ADDR_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  dn_mem[s] <= '0;
      else if (we) dn_mem[s] <= wr_data;
    end
  end

  always_comb begin
    bsel = POS_W'(SLOT_BITS - 1) - pos_nxt;
    dn_d = dn_q;
    if (bit_adv) dn_d = dn_mem[slot_nxt][bsel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dn_q <= 1'b0;
    else        dn_q <= dn_d;
  end

  assign ser_dn_o = dn_q;
endmodule

// File: rtl/gci_tsi_rx.sv
module gci_tsi_rx
  import gci_tsi_pkg::*;
#(
  parameter int unsigned NSLOT     = 12,
  parameter int unsigned SLOT_BITS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         samp,
  input  logic [SLOT_FIELD_W-1:0]      slot_cur,
  input  logic [$clog2(SLOT_BITS)-1:0] pos_cur,
  input  logic                         ser_up_i,
  input  logic [REG_ADDR_W-1:0]        rd_addr,
  output logic [SLOT_BITS-1:0]         rd_data
);
  localparam int unsigned POS_W = $clog2(SLOT_BITS);

  logic [NSLOT-1:0][SLOT_BITS-1:0] up_mem;
  logic [SLOT_BITS-1:0]            sh_q, sh_d;
  logic                            last_bit;

  always_comb begin
    sh_d     = sh_q;
    if (samp) sh_d = {sh_q[SLOT_BITS-2:0], ser_up_i};
    last_bit = samp && (pos_cur == POS_W'(SLOT_BITS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic we;
    assign we = last_bit && (slot_cur == SLOT_FIELD_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  up_mem[s] <= '0;
      else if (we) up_mem[s] <= sh_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < REG_ADDR_W'(NSLOT)) rd_data = up_mem[rd_addr[SLOT_FIELD_W-1:0]];
  end
endmodule

// File: rtl/gci_tsi_strobe.sv
module gci_tsi_strobe
  import gci_tsi_pkg::*;
#(
  parameter int unsigned REG_ADDR  = 12,
  parameter int unsigned SLOT_BITS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [REG_ADDR_W-1:0]   wr_addr,
  input  logic [SLOT_BITS-1:0]    wr_data,
  input  logic                    bit_adv,
  input  logic [SLOT_FIELD_W-1:0] slot_nxt,
  output logic                    strb_o
);
  localparam int unsigned EN_BIT = SLOT_BITS - 1;

  strb_cfg_t cfg_q, cfg_d;
  logic      strb_q, strb_d;
  logic      hit;

  always_comb begin
    hit   = wr_en && (wr_addr == REG_ADDR_W'(REG_ADDR));
    cfg_d = cfg_q;
    if (hit) begin
      cfg_d.en   = wr_data[EN_BIT];
      cfg_d.slot = wr_data[SLOT_FIELD_W-1:0];
    end
    strb_d = strb_q;
    if (bit_adv) strb_d = cfg_q.en && (cfg_q.slot == slot_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      strb_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      strb_q <= strb_d;
    end
  end

  assign strb_o = strb_q;
endmodule

// File: rtl/gci_tsi.sv
module gci_tsi
  import gci_tsi_pkg::*;
#(
  parameter int unsigned NSLOT      = 12,
  parameter int unsigned SLOT_BITS  = 8,
  parameter int unsigned MC_PER_BIT = 10,
  parameter int unsigned NSTRB      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [3:0]            wr_addr,
  input  logic [SLOT_BITS-1:0]  wr_data,
  input  logic [3:0]            rd_addr,
  output logic [SLOT_BITS-1:0]  rd_data,
  input  logic                  ser_up_i,
  output logic                  ser_dn_o,
  output logic                  bit_clk_o,
  output logic                  dat_clk_o,
  output logic                  frame_sync_o,
  output logic [NSTRB-1:0]      slot_strobe_o
);
  localparam int unsigned NBITS = NSLOT * SLOT_BITS;
  localparam int unsigned POS_W = $clog2(SLOT_BITS);

  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  logic                    bit_adv, samp;
  logic [SLOT_FIELD_W-1:0] slot_nxt, slot_cur;
  logic [POS_W-1:0]        pos_nxt, pos_cur;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  gci_tsi_clkgen #(
    .MC_PER_BIT(MC_PER_BIT), .NBITS(NBITS), .SLOT_BITS(SLOT_BITS)
  ) u_clkgen (
    .clk(clk), .rst_n(rst_int_n),
    .bit_adv_o(bit_adv), .samp_o(samp),
    .slot_nxt_o(slot_nxt), .pos_nxt_o(pos_nxt),
    .slot_cur_o(slot_cur), .pos_cur_o(pos_cur),
    .bit_clk_o(bit_clk_o), .dat_clk_o(dat_clk_o), .frame_sync_o(frame_sync_o)
  );

  gci_tsi_tx #(.NSLOT(NSLOT), .SLOT_BITS(SLOT_BITS)) u_tx (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bit_adv(bit_adv), .slot_nxt(slot_nxt), .pos_nxt(pos_nxt),
    .ser_dn_o(ser_dn_o)
  );

  gci_tsi_rx #(.NSLOT(NSLOT), .SLOT_BITS(SLOT_BITS)) u_rx (
    .clk(clk), .rst_n(rst_int_n),
    .samp(samp), .slot_cur(slot_cur), .pos_cur(pos_cur),
    .ser_up_i(ser_up_i), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  for (genvar k = 0; k < NSTRB; k++) begin : g_strb
    gci_tsi_strobe #(.REG_ADDR(NSLOT + k), .SLOT_BITS(SLOT_BITS)) u_strb (
      .clk(clk), .rst_n(rst_int_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .bit_adv(bit_adv), .slot_nxt(slot_nxt),
      .strb_o(slot_strobe_o[k])
    );
  end
endmodule

// File: rtl/gci_tsi_chk.sv
module gci_tsi_chk #(
  parameter int unsigned NSLOT     = 12,
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned NSTRB     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bit_clk_o,
  input logic                 dat_clk_o,
  input logic                 frame_sync_o,
  input logic                 ser_dn_o,
  input logic [NSTRB-1:0]     slot_strobe_o,
  input logic [3:0]           rd_addr,
  input logic [SLOT_BITS-1:0] rd_data
);
  AST_BCLK_RISE_WITH_DCLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_clk_o) |-> $rose(dat_clk_o)); // R2
  AST_BCLK_FALL_DCLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bit_clk_o) |-> $rose(dat_clk_o)); // R1
  AST_FSYNC_START_OF_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_sync_o) |-> $rose(bit_clk_o)); // R3
  AST_FSYNC_ONE_DCLK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_sync_o) |-> $fell(bit_clk_o)); // R3
  AST_DN_AT_BIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(bit_clk_o) |-> $stable(ser_dn_o)); // R4
  AST_STRB_AT_BIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(bit_clk_o) |-> $stable(slot_strobe_o)); // R6
  AST_RD_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr >= 4'(NSLOT)) |-> (rd_data == '0)); // R10
endmodule

bind gci_tsi gci_tsi_chk #(.NSLOT(NSLOT), .SLOT_BITS(SLOT_BITS), .NSTRB(NSTRB)) u_gci_tsi_chk (
  .clk(clk), .rst_n(rst_n), .bit_clk_o(bit_clk_o), .dat_clk_o(dat_clk_o),
  .frame_sync_o(frame_sync_o), .ser_dn_o(ser_dn_o), .slot_strobe_o(slot_strobe_o),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/test_gci_tsi.sv
`timescale 1ns/1ps
module test_gci_tsi;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] rd_addr;
  logic [7:0] rd_data;
  logic       up_in;
  logic       ser_dn_o, bit_clk_o, dat_clk_o, frame_sync_o;
  logic [1:0] slot_strobe_o;

  gci_tsi i_gci_tsi (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ser_up_i(up_in), .ser_dn_o(ser_dn_o),
    .bit_clk_o(bit_clk_o), .dat_clk_o(dat_clk_o), .frame_sync_o(frame_sync_o),
    .slot_strobe_o(slot_strobe_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int       m_edges, m_mc, m_bit;
  logic     m_bclk, m_dclk, m_fs, m_dn;
  logic [1:0] m_strb;
  logic [7:0] m_dnbuf [12];
  logic [7:0] m_upbuf [12];
  logic [7:0] m_sh;
  logic     m_en [2];
  int       m_slot [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_edges = 0; m_mc = 9; m_bit = 95;
      m_bclk = 0; m_dclk = 0; m_fs = 0; m_dn = 0; m_strb = '0; m_sh = '0;
      for (int i = 0; i < 12; i++) begin m_dnbuf[i] = '0; m_upbuf[i] = '0; end
      for (int k = 0; k < 2; k++) begin m_en[k] = 0; m_slot[k] = 0; end
    end else if (m_edges < 2) begin
      m_edges++;
    end else begin
      m_mc++;
      if (m_mc == 10) begin m_mc = 0; m_bit = (m_bit + 1) % 96; end
      m_bclk = (m_mc < 5);
      m_dclk = ((m_mc % 5) < 3);
      m_fs   = (m_bit == 0) && (m_mc < 5);
      if (m_mc == 0) begin
        m_dn = m_dnbuf[m_bit / 8][7 - (m_bit % 8)];
        for (int k = 0; k < 2; k++) m_strb[k] = m_en[k] && (m_slot[k] == m_bit / 8);
      end
      if (m_mc == 5) begin
        m_sh = {m_sh[6:0], up_in};
        if (m_bit % 8 == 7) m_upbuf[m_bit / 8] = m_sh;
      end
      if (wr_en) begin
        if (wr_addr < 12) m_dnbuf[wr_addr] = wr_data;
        else if (wr_addr < 14) begin
          m_en[wr_addr - 12]   = wr_data[7];
          m_slot[wr_addr - 12] = int'(wr_data[3:0]);
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", req, what, $time, got, exp);
    end
  endtask

  logic in_reset;
  // compare every cycle, after inputs driven at negedge have settled
  always @(negedge clk) begin
    #2;
    if (in_reset) begin
      chk("R9", "bit clock in reset", {7'b0, bit_clk_o}, 8'h00);
      chk("R9", "data clock in reset", {7'b0, dat_clk_o}, 8'h00);
      chk("R9", "frame sync in reset", {7'b0, frame_sync_o}, 8'h00);
      chk("R9", "down data in reset", {7'b0, ser_dn_o}, 8'h00);
      chk("R9", "strobes in reset", {6'b0, slot_strobe_o}, 8'h00);
      chk("R9", "read data in reset", rd_data, 8'h00);
    end else begin
      chk("R1", "bit clock", {7'b0, bit_clk_o}, {7'b0, m_bclk});
      chk("R2", "data clock", {7'b0, dat_clk_o}, {7'b0, m_dclk});
      chk("R3", "frame sync", {7'b0, frame_sync_o}, {7'b0, m_fs});
      chk("R4", "down data", {7'b0, ser_dn_o}, {7'b0, m_dn});
      for (int k = 0; k < 2; k++) begin
        if (!m_en[k])           chk("R7", "disabled strobe", {7'b0, slot_strobe_o[k]}, {7'b0, m_strb[k]});
        else if (m_slot[k] >= 12) chk("R8", "out-of-range strobe", {7'b0, slot_strobe_o[k]}, {7'b0, m_strb[k]});
        else                    chk("R6", "strobe", {7'b0, slot_strobe_o[k]}, {7'b0, m_strb[k]});
      end
      if (rd_addr >= 12) chk("R10", "read out of range", rd_data, 8'h00);
      else               chk("R5", "captured byte", rd_data, m_upbuf[rd_addr]);
    end
  end

  // stimulus: pseudo-random upstream bit each cycle, sweeping read address
  logic [15:0] lfsr;
  always @(negedge clk) begin
    if (!rst_n) begin
      lfsr    <= 16'hACE1;
      up_in   <= 1'b0;
      rd_addr <= 4'd0;
    end else begin
      lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      up_in   <= lfsr[0];
      rd_addr <= rd_addr + 4'd1;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_reset = 1'b1;
    idle(4);
    rst_n = 1'b1; in_reset = 1'b0;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired (R1..R10 incomplete)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  localparam logic [7:0] PAT_A [12] = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81, 8'h7E,
                                        8'h01, 8'h80, 8'h55, 8'hC3, 8'h0F, 8'hF0};

  initial begin
    rst_n = 1'b0; in_reset = 1'b1;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    idle(4);
    rst_n = 1'b1; in_reset = 1'b0;
    // all-zero downstream, strobes unset (R4, R7)
    idle(1000);
    // mixed patterns, strobes on slot 3 and slot 11 (R4, R6)
    for (int s = 0; s < 12; s++) wr(4'(s), PAT_A[s]);
    wr(4'd12, 8'h83);
    wr(4'd13, 8'h8B);
    idle(2000);
    // mid-frame rewrites, disabled strobe, out-of-range slot, unused addresses (R4, R7, R8)
    idle(37);
    for (int s = 0; s < 12; s++) wr(4'(s), ~PAT_A[11 - s]);
    wr(4'd12, 8'h03);
    wr(4'd13, 8'h8C);
    wr(4'd14, 8'hFF);
    wr(4'd15, 8'h8F);
    idle(1500);
    // slot 0 next to frame sync, slot 5 (R6)
    wr(4'd12, 8'h80);
    wr(4'd13, 8'h85);
    idle(1200);
    // reset in the middle of a frame (R9), then framing restarts
    do_reset();
    idle(300);
    wr(4'd13, 8'h82);
    wr(4'd2, 8'h96);
    idle(1200);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule